// File: doc/BRIEF.md
# Quadrature XOR Phase Detector

This block compares two digital signals whose frequencies are nearly the same. Each input is asynchronous to the system clock, so each one first passes through a two-stage synchroniser and a rising-edge detector. Every detected rising edge moves a two-bit twisted-ring counter one step. The counter divides its input by four and gives two outputs a quarter of a divided period apart: an in-phase bit and a quadrature bit.

Two exclusive-OR detectors compare like phases of the two counters. Because the detectors sit 90 degrees apart, the two averaged outputs form a pair of triangular curves offset by a quarter turn, and at any phase one of them is on a linear slope. Over a programmable window of system-clock cycles the block counts how many cycles each detector output is high. It then hands the two duty counts out on a valid/ready result port.

The result port holds one result. `res_valid` rises at the end of each window and stays high, with the data held, until the cycle in which `res_ready` is high. The windows keep running while the port is stalled. If a window closes while its result is still unaccepted, the newer counts replace the older ones and `res_valid` stays high, so the consumer always sees the latest window. Inputs above roughly a quarter of the system clock rate are outside the usable range and must be divided down first.

Top module: `quad_xor_phase_det`

## Requirements
- R1: Each input is taken through two synchronising flops. A rising edge seen after the second flop advances that input's counter. A level change applied before clock edge k shows up in the counter state after edge k+2.
- R2: Each counter steps 00, 01, 11, 10 and then back to 00, one step per detected rising edge. Exactly one bit changes per step, and the state holds when there is no edge. Bit 0 is the in-phase output and bit 1 is the quadrature output.
- R3: The in-phase detector is bit 0 of counter A XOR bit 0 of counter B. The quadrature detector is bit 1 of counter A XOR bit 1 of counter B.
- R4: A window lasts `win_len` system cycles, and values 0 and 1 both give a one-cycle window. `duty_i` and `duty_q` report how many cycles of the window each detector was high. The accumulators restart from zero for the next window.
- R5: `res_valid` rises in the cycle after a window closes. Data and valid then hold steady until a cycle with `res_ready` high, after which valid drops unless another window closes at that same edge.
- R6: When a window closes while a result is still pending, the new counts replace the pending ones and `res_valid` stays high.
- R7: A synchronous reset clears both counters to 00, the synchronisers, the window counter, the accumulators and the result port.
- R8: Identical inputs give both counts zero. Counter A one step ahead of B gives `duty_i + duty_q = win_len`. Counter A two steps ahead gives both counts equal to `win_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| sig_a | input | 1 | first asynchronous input signal |
| sig_b | input | 1 | second asynchronous input signal |
| win_len | input | WIN_W | window length in system cycles |
| res_ready | input | 1 | consumer accepts the result this cycle |
| res_valid | output | 1 | result pending |
| duty_i | output | WIN_W | high-cycle count of the in-phase detector |
| duty_q | output | WIN_W | high-cycle count of the quadrature detector |

## Verification
The bench builds the block with `WIN_W = 6`, so window lengths up to 63 fit and many windows complete in a short run. This makes it practical to reach a window that closes while a result is still stalled, to run one-cycle windows at lengths 0 and 1, and to hold the counters at fixed relative offsets long enough to check the exact sums and equalities of R8.

// File: rtl/qxpd_pkg.sv
package qxpd_pkg;
  // two-bit twisted-ring divider state: bit 0 in-phase, bit 1 quadrature
  typedef logic [1:0] quad_t;
  localparam int unsigned NUM_IN    = 2;
  localparam int unsigned NUM_PHASE = 2;
  localparam quad_t       QUAD_RST  = 2'b00;

  function automatic quad_t quad_next(input quad_t s);
    return {s[0], ~s[1]};
  endfunction
endpackage

// File: rtl/qxpd_sync_edge.sv
module qxpd_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // sh[0], sh[1]: synchroniser; sh[2]: previous synchronised level
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], async_in};
  end

  assign rise = sh[1] & ~sh[2];

  p_single_rise_r1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/qxpd_johnson.sv
module qxpd_johnson
  import qxpd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  output quad_t ph
);
  always_ff @(posedge clk) begin
    if (rst)      ph <= QUAD_RST;
    else if (adv) ph <= quad_next(ph);
  end

  p_one_bit_step_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> ($countones(ph ^ $past(ph)) == 1));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ph));
  p_rst_clear_r7: assert property (@(posedge clk)
    rst |=> (ph == QUAD_RST));
endmodule

// File: rtl/qxpd_duty_window.sv
module qxpd_duty_window
  import qxpd_pkg::*;
#(
  parameter int unsigned WIN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PHASE-1:0] det,
  input  logic [WIN_W-1:0]     win_len,
  input  logic                 res_ready,
  output logic                 res_valid,
  output logic [WIN_W-1:0]     duty_i,
  output logic [WIN_W-1:0]     duty_q
);
  localparam int unsigned EXT_W = WIN_W + 1;

  logic [WIN_W-1:0] cnt;
  logic [WIN_W-1:0] acc  [NUM_PHASE];
  logic [WIN_W-1:0] accn [NUM_PHASE];
  logic             win_end;

  assign win_end = ({1'b0, cnt} + EXT_W'(1)) >= {1'b0, win_len};

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (win_end) cnt <= '0;
    else              cnt <= cnt + WIN_W'(1);
  end

  for (genvar p = 0; p < NUM_PHASE; p++) begin : g_acc
    assign accn[p] = acc[p] + WIN_W'(det[p]);
    always_ff @(posedge clk) begin
      if (rst || win_end) acc[p] <= '0;
      else                acc[p] <= accn[p];
    end
    p_acc_bound_r4: assert property (@(posedge clk) disable iff (rst)
      acc[p] <= cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      duty_i    <= '0;
      duty_q    <= '0;
    end else if (win_end) begin
      res_valid <= 1'b1;
      duty_i    <= accn[0];
      duty_q    <= accn[1];
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready && !win_end) |=>
      (res_valid && $stable(duty_i) && $stable(duty_q)));
  p_accept_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready && !win_end) |=> !res_valid);
  p_window_valid_r6: assert property (@(posedge clk) disable iff (rst)
    win_end |=> res_valid);
endmodule

// File: rtl/quad_xor_phase_det.sv
module quad_xor_phase_det
  import qxpd_pkg::*;
#(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_a,
  input  logic             sig_b,
  input  logic [WIN_W-1:0] win_len,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [WIN_W-1:0] duty_i,
  output logic [WIN_W-1:0] duty_q
);
  logic [NUM_IN-1:0]    sig_in;
  logic [NUM_IN-1:0]    rise;
  quad_t                ph [NUM_IN];
  logic [NUM_PHASE-1:0] det;

  assign sig_in = {sig_b, sig_a};

  for (genvar n = 0; n < NUM_IN; n++) begin : g_in
    qxpd_sync_edge u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (sig_in[n]),
      .rise     (rise[n])
    );
    qxpd_johnson u_div (
      .clk (clk),
      .rst (rst),
      .adv (rise[n]),
      .ph  (ph[n])
    );
  end

  for (genvar p = 0; p < NUM_PHASE; p++) begin : g_det
    assign det[p] = ph[0][p] ^ ph[1][p];
  end

  qxpd_duty_window #(.WIN_W(WIN_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .det       (det),
    .win_len   (win_len),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .duty_i    (duty_i),
    .duty_q    (duty_q)
  );
endmodule

// File: tb/quad_xor_phase_det_bench.sv
module quad_xor_phase_det_bench;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sig_a = 1'b0, sig_b = 1'b0;
  logic [W-1:0] win_len = W'(20);
  logic         res_ready = 1'b1;
  logic         res_valid;
  logic [W-1:0] duty_i, duty_q;

  always #2.5 clk = ~clk;

  quad_xor_phase_det #(.WIN_W(W)) u_quad_xor_phase_det (
    .clk(clk), .rst(rst), .sig_a(sig_a), .sig_b(sig_b), .win_len(win_len),
    .res_ready(res_ready), .res_valid(res_valid), .duty_i(duty_i), .duty_q(duty_q)
  );

  typedef struct packed { logic [W-1:0] i; logic [W-1:0] q; } item_t;
  item_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  int mode = -1;   // -1 none, 0 in phase, 1 one step, 2 two steps (R8)
  bit done = 0;

  // requirement model: synchroniser, divider, window, result port
  logic [2:0] m_sa = '0, m_sb = '0;
  logic [1:0] m_ja = '0, m_jb = '0;
  int m_cnt = 0, m_i = 0, m_q = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_sa = '0; m_sb = '0; m_ja = '0; m_jb = '0;
      m_cnt = 0; m_i = 0; m_q = 0;
      exp_q.delete();
    end else begin
      bit ra, rb, xi, xq;
      item_t it;
      ra = m_sa[1] & ~m_sa[2];
      rb = m_sb[1] & ~m_sb[2];
      xi = m_ja[0] ^ m_jb[0];   // R3
      xq = m_ja[1] ^ m_jb[1];
      if (exp_q.size() > 0 && res_ready) void'(exp_q.pop_front());
      m_i += int'(xi); m_q += int'(xq);
      if (m_cnt + 1 >= int'(win_len)) begin   // R4
        it.i = W'(m_i); it.q = W'(m_q);
        if (exp_q.size() > 0) exp_q[0] = it;  // R6 replace pending
        else exp_q.push_back(it);
        m_cnt = 0; m_i = 0; m_q = 0;
      end else m_cnt++;
      if (ra) m_ja = {m_ja[0], ~m_ja[1]};     // R2 sequence
      if (rb) m_jb = {m_jb[0], ~m_jb[1]};
      m_sa = {m_sa[1:0], sig_a};               // R1
      m_sb = {m_sb[1:0], sig_b};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(res_valid == (exp_q.size() > 0), "R5 valid", int'(res_valid), exp_q.size());
      if (res_valid && res_ready && exp_q.size() > 0) begin
        chk(duty_i == exp_q[0].i, "R4 duty_i", int'(duty_i), int'(exp_q[0].i));
        chk(duty_q == exp_q[0].q, "R4 duty_q", int'(duty_q), int'(exp_q[0].q));
        if (mode == 0) begin
          chk(duty_i == 0, "R8 in-phase i", int'(duty_i), 0);
          chk(duty_q == 0, "R8 in-phase q", int'(duty_q), 0);
        end else if (mode == 1)
          chk(int'(duty_i) + int'(duty_q) == int'(win_len), "R8 quarter sum",
              int'(duty_i) + int'(duty_q), int'(win_len));
        else if (mode == 2) begin
          chk(duty_i == win_len, "R8 half i", int'(duty_i), int'(win_len));
          chk(duty_q == win_len, "R8 half q", int'(duty_q), int'(win_len));
        end
      end
    end
  end

  // driver
  task automatic toggle_both(input int periods, input int half);
    for (int k = 0; k < periods; k++) begin
      repeat (half) @(negedge clk);
      sig_a = 1'b1; sig_b = 1'b1;
      repeat (half) @(negedge clk);
      sig_a = 1'b0; sig_b = 1'b0;
    end
  endtask

  task automatic pulse_a();
    @(negedge clk); sig_a = 1'b1;
    repeat (4) @(negedge clk); sig_a = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic offset_run(input int a_half, input int b_half, input int cycles);
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      sig_a = ((t / a_half) % 2) == 1;
      sig_b = ((t / b_half) % 2) == 1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(res_valid == 1'b0, "R7 reset valid", int'(res_valid), 0);
    chk(duty_i == 0 && duty_q == 0, "R7 reset data", int'(duty_i), 0);
    rst = 1'b0;
    // in phase (R8)
    toggle_both(4, 3);
    mode = 0; toggle_both(12, 3); mode = -1;
    // A one step ahead (R2, R8)
    pulse_a(); toggle_both(6, 3);
    mode = 1; toggle_both(12, 3); mode = -1;
    // A two steps ahead
    pulse_a(); toggle_both(6, 3);
    mode = 2; toggle_both(12, 3); mode = -1;
    // drifting frequencies (R1..R4)
    offset_run(3, 4, 400);
    offset_run(5, 3, 300);
    // back-pressure and overwrite (R5, R6)
    win_len = W'(7);
    @(negedge clk); res_ready = 1'b0;
    offset_run(2, 3, 40);
    res_ready = 1'b1;
    offset_run(4, 3, 60);
    // one-cycle windows (R4)
    win_len = W'(0); offset_run(3, 2, 30);
    win_len = W'(1); offset_run(2, 4, 30);
    win_len = W'(63); offset_run(3, 5, 200);
    // mid-run reset (R7)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(res_valid == 1'b0, "R7 mid reset valid", int'(res_valid), 0);
    rst = 1'b0; win_len = W'(9);
    offset_run(4, 4, 80);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule